// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block chooses the address of the next instruction for a 32-bit processor whose branches and jumps have one architectural delay slot. Each cycle it receives the instruction word that is executing, that instruction's address, and the two source register values. It recognises the conditional branches, the direct jumps and the jumps through a register. It evaluates branch conditions with signed comparisons and forms the relative, absolute or register target. For the linking forms it supplies a link write: the register index and the return address.

A taken control transfer does not redirect at once. The unit latches the target and loads a two-step slot counter. The instruction right after the branch then executes, and only when that delay-slot instruction completes does the next PC become the latched target. A branch or jump that sits in a delay slot is ignored. The unit raises an idle flag when a delay slot holds the all-zero word and the pending target is the branch itself, which is the usual form of a spin-wait loop. A stall input freezes the unit. A flush input from the exception logic drops any pending redirect.

Top module: `delay_slot_npc`

## Requirements
- R1: With no redirect pending, and with stall low, nextPc equals curPc + 4.
- R2: A taken branch or jump that executes outside a delay slot reports nextPc = curPc + 4 in its own cycle. In the following executed cycle (the delay slot), nextPc is the latched target with bits [1:0] forced to zero. In the executed cycle after that, nextPc is again curPc + 4.
- R3: A branch or jump that executes while a redirect is pending (in a delay slot) has no effect. It neither changes the pending target nor asserts linkWe.
- R4: Conditional branches use the relative target curPc + 4 + (sign-extended instrWord[15:0] << 2).
- R5: Opcodes 2 and 3 (instrWord[31:26]) use the absolute target {curPc[31:28], instrWord[25:0], 2'b00}.
- R6: Opcode 0 with function field instrWord[5:0] = 8 (jump via register) or 9 (jump-and-link via register) is always taken and targets rsVal.
- R7: Opcodes 4, 5, 6 and 7 are taken when rsVal == rtVal, rsVal != rtVal, rsVal <= 0 and rsVal > 0 respectively, comparing as signed numbers.
- R8: Opcode 1 selects by instrWord[20:16]. Code 0x00 is taken if rsVal < 0, 0x01 if rsVal >= 0, 0x10 if rsVal < 0 with link, and 0x11 if rsVal >= 0 with link. Every other code is not a control transfer and has no effect.
- R9: linkVal equals curPc + 8 whenever linkWe is high. Opcode 3 always links to register 31. The opcode-1 link codes link to register 31 only when taken. Function 9 always links to the register named by instrWord[15:11].
- R10: idleFlag is high in a delay-slot cycle exactly when instrWord is all zeros and the latched target equals curPc - 4.
- R11: While stall is high, nextPc equals curPc, no link write is requested and no state changes.
- R12: flush cancels any pending redirect in the cycle it is high. nextPc is then curPc + 4 (or curPc if stall is also high), and the following cycle behaves as R1.
- R13: After reset no redirect is pending, so nextPc is curPc + 4 and idleFlag is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold: the current instruction does not complete this cycle |
| flush | input | 1 | Cancel a pending redirect (exception taken) |
| instrWord | input | 32 | Instruction executing this cycle |
| curPc | input | 32 | Address of that instruction |
| rsVal | input | 32 | Value of source register rs |
| rtVal | input | 32 | Value of source register rt |
| nextPc | output | 32 | Address of the next instruction |
| linkWe | output | 1 | Link register write request |
| linkIdx | output | 5 | Link register index |
| linkVal | output | 32 | Return address to write |
| idleFlag | output | 1 | Delay-slot nop loop detected |

## Verification
The outputs are combinational from the present inputs and two registers: the slot counter and the latched target. The link and idle results, and the curPc + 4 of the branch's own cycle, are due in the cycle the instruction is presented. The redirect is due exactly one executed cycle later, in the delay-slot cycle. The return to sequential addresses is due one executed cycle after that. The bench drives each instruction just after a rising edge and samples half a period later, before the next edge. It then steps one edge per instruction, so each three-cycle branch sequence is checked at the cycle where each result is due, including the cases where a stall or a flush falls inside the sequence.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int XLEN      = 32;
  localparam int REG_IDX_W = 5;
  localparam int SLOT_LOAD = 2;
  localparam int CNT_W     = $clog2(SLOT_LOAD + 1);
  localparam int LINK_REG  = 31;

  typedef enum logic [1:0] {
    TGT_REL = 2'd0,
    TGT_ABS = 2'd1,
    TGT_REG = 2'd2
  } tgtSel_e;

  typedef struct packed {
    logic    loadTarget;
    logic    clearTarget;
    tgtSel_e tgtSel;
    logic    redirect;
    logic    holdPc;
    logic    slotNop;
    logic    linkWe;
    logic    linkRd;
  } npcStrobes_t;
endpackage

// File: rtl/npc_ctrl.sv
module npc_ctrl
  import npc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              flush,
  input  logic [XLEN-1:0]   instrWord,
  input  logic [XLEN-1:0]   rsVal,
  input  logic [XLEN-1:0]   rtVal,
  output npcStrobes_t       strobes,
  output logic [CNT_W-1:0]  slotCnt
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic [4:0] rtCode;
  logic isJr, isJalr, isRegimm, isJ, isJal, isCond, isCtl;
  logic rsNeg, rsZero, opsEq, condTrue, taken;
  logic exec, inSlot, act;

  assign opc    = instrWord[31:26];
  assign fn     = instrWord[5:0];
  assign rtCode = instrWord[20:16];

  assign isJr     = (opc == 6'd0) && (fn == 6'd8);
  assign isJalr   = (opc == 6'd0) && (fn == 6'd9);
  assign isRegimm = (opc == 6'd1) &&
                    ((rtCode == 5'h00) || (rtCode == 5'h01) ||
                     (rtCode == 5'h10) || (rtCode == 5'h11));
  assign isJ      = (opc == 6'd2);
  assign isJal    = (opc == 6'd3);
  assign isCond   = (opc >= 6'd4) && (opc <= 6'd7);
  assign isCtl    = isJr | isJalr | isRegimm | isJ | isJal | isCond;

  assign rsNeg  = rsVal[XLEN-1];
  assign rsZero = (rsVal == '0);
  assign opsEq  = (rsVal == rtVal);

  always_comb begin
    unique case (opc)
      6'd1:    condTrue = rtCode[0] ? !rsNeg : rsNeg;
      6'd4:    condTrue = opsEq;
      6'd5:    condTrue = !opsEq;
      6'd6:    condTrue = rsNeg | rsZero;
      6'd7:    condTrue = !rsNeg && !rsZero;
      default: condTrue = 1'b1;
    endcase
  end

  assign taken  = isCtl & condTrue;
  assign exec   = !stall && !flush;
  assign inSlot = (slotCnt != '0);
  assign act    = exec && !inSlot;

  always_comb begin
    strobes.loadTarget  = act & taken;
    strobes.clearTarget = flush;
    if (isJr || isJalr)     strobes.tgtSel = TGT_REG;
    else if (isJ || isJal)  strobes.tgtSel = TGT_ABS;
    else                    strobes.tgtSel = TGT_REL;
    strobes.redirect = exec && (slotCnt == CNT_W'(1));
    strobes.holdPc   = stall;
    strobes.slotNop  = (instrWord == '0);
    strobes.linkWe   = act & (isJal | isJalr | (isRegimm & rtCode[4] & condTrue));
    strobes.linkRd   = isJalr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                slotCnt <= '0;
    else if (flush)            slotCnt <= '0;
    else if (exec) begin
      if (inSlot)              slotCnt <= slotCnt - CNT_W'(1);
      else if (taken)          slotCnt <= CNT_W'(SLOT_LOAD - 1);
    end
  end
endmodule

// File: rtl/npc_path.sv
module npc_path
  import npc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  npcStrobes_t          strobes,
  input  logic [XLEN-1:0]      instrWord,
  input  logic [XLEN-1:0]      curPc,
  input  logic [XLEN-1:0]      rsVal,
  output logic [XLEN-1:0]      nextPc,
  output logic [REG_IDX_W-1:0] linkIdx,
  output logic [XLEN-1:0]      linkVal,
  output logic                 idleFlag
);
  logic [XLEN-1:0] seqPc, relTgt, absTgt, newTgt, heldTgt;

  assign seqPc  = curPc + XLEN'(4);
  assign relTgt = seqPc + {{(XLEN-18){instrWord[15]}}, instrWord[15:0], 2'b00};
  assign absTgt = {curPc[XLEN-1:28], instrWord[25:0], 2'b00};

  always_comb begin
    unique case (strobes.tgtSel)
      TGT_ABS: newTgt = absTgt;
      TGT_REG: newTgt = rsVal;
      default: newTgt = relTgt;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  heldTgt <= '0;
    else if (strobes.clearTarget) heldTgt <= '0;
    else if (strobes.loadTarget)  heldTgt <= newTgt;
  end

  always_comb begin
    if (strobes.holdPc)        nextPc = curPc;
    else if (strobes.redirect) nextPc = {heldTgt[XLEN-1:2], 2'b00};
    else                       nextPc = seqPc;
  end

  assign linkVal  = curPc + XLEN'(8);
  assign linkIdx  = strobes.linkRd ? instrWord[15:11] : REG_IDX_W'(LINK_REG);
  assign idleFlag = strobes.redirect && strobes.slotNop && (heldTgt == curPc - XLEN'(4));
endmodule

// File: rtl/delay_slot_npc.sv
module delay_slot_npc
  import npc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stall,
  input  logic                 flush,
  input  logic [XLEN-1:0]      instrWord,
  input  logic [XLEN-1:0]      curPc,
  input  logic [XLEN-1:0]      rsVal,
  input  logic [XLEN-1:0]      rtVal,
  output logic [XLEN-1:0]      nextPc,
  output logic                 linkWe,
  output logic [REG_IDX_W-1:0] linkIdx,
  output logic [XLEN-1:0]      linkVal,
  output logic                 idleFlag
);
  npcStrobes_t      strobes;
  logic [CNT_W-1:0] slotCnt;

  npc_ctrl i_ctrl (
    .clk(clk), .rst_n(rst_n), .stall(stall), .flush(flush),
    .instrWord(instrWord), .rsVal(rsVal), .rtVal(rtVal),
    .strobes(strobes), .slotCnt(slotCnt)
  );

  npc_path i_path (
    .clk(clk), .rst_n(rst_n), .strobes(strobes), .instrWord(instrWord),
    .curPc(curPc), .rsVal(rsVal), .nextPc(nextPc), .linkIdx(linkIdx),
    .linkVal(linkVal), .idleFlag(idleFlag)
  );

  assign linkWe = strobes.linkWe;
endmodule

// File: rtl/npc_checker.sv
module npc_checker
  import npc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             stall,
  input logic             flush,
  input logic [XLEN-1:0]  curPc,
  input logic [XLEN-1:0]  nextPc,
  input logic             linkWe,
  input logic [XLEN-1:0]  linkVal,
  input logic             idleFlag,
  input logic [CNT_W-1:0] slotCnt
);
  logic [XLEN-1:0] prevPc;
  assign prevPc = curPc - XLEN'(4);

  a_r1_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (slotCnt == '0 && !stall) |-> nextPc == curPc + XLEN'(4));

  a_r2_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (slotCnt != '0 && !stall && !flush) |=> slotCnt == $past(slotCnt) - CNT_W'(1));

  a_r9_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    linkWe |-> (linkVal == curPc + XLEN'(8)) && !stall);

  a_r10_idle_self: assert property (@(posedge clk) disable iff (!rst_n)
    idleFlag |-> nextPc[XLEN-1:2] == prevPc[XLEN-1:2]);

  a_r11_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> nextPc == curPc);

  a_r11_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !flush) |=> $stable(slotCnt));

  a_r12_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> slotCnt == '0);
endmodule

bind delay_slot_npc npc_checker i_chk (.*);

// File: tb/test_delay_slot_npc.sv
module test_delay_slot_npc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall = 1'b0;
  logic        flush = 1'b0;
  logic [31:0] instrWord = '0;
  logic [31:0] curPc = '0;
  logic [31:0] rsVal = '0;
  logic [31:0] rtVal = '0;
  logic [31:0] nextPc;
  logic        linkWe;
  logic [4:0]  linkIdx;
  logic [31:0] linkVal;
  logic        idleFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  delay_slot_npc i_delay_slot_npc (.*);

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic present(input logic [31:0] ins, input logic [31:0] pc,
                         input logic [31:0] rs, input logic [31:0] rt);
    instrWord = ins; curPc = pc; rsVal = rs; rtVal = rt;
    #1;
  endtask

  task automatic stepEdge();
    @(posedge clk); #1;
  endtask

  function automatic logic [31:0] enc(input int op, input int rtF, input logic [15:0] imm);
    return {6'(op), 5'd3, 5'(rtF), imm};
  endfunction

  function automatic logic [31:0] relOf(input logic [31:0] pc, input logic [15:0] imm);
    return pc + 32'd4 + ({{16{imm[15]}}, imm} << 2);
  endfunction

  // Branch / slot / landing sequence
  task automatic runSeq(input string tag, input logic [31:0] ins, input logic [31:0] pc,
                        input logic [31:0] rs, input logic [31:0] rt, input bit expTaken,
                        input logic [31:0] expTgt, input bit expLink, input logic [4:0] expIdx);
    logic [31:0] land;
    present(ins, pc, rs, rt);
    chk({tag, " R2 own-cycle pc+4"}, nextPc, pc + 32'd4);
    chk({tag, " R9 linkWe"}, {31'd0, linkWe}, {31'd0, expLink});
    if (expLink) begin
      chk({tag, " R9 linkVal"}, linkVal, pc + 32'd8);
      chk({tag, " R9 linkIdx"}, {27'd0, linkIdx}, {27'd0, expIdx});
    end
    stepEdge();
    present(32'h0000_0000, pc + 32'd4, 32'd0, 32'd0);
    land = expTaken ? {expTgt[31:2], 2'b00} : pc + 32'd8;
    chk({tag, " R2 slot redirect"}, nextPc, land);
    stepEdge();
    present(32'h0000_0000, land, 32'd0, 32'd0);
    chk({tag, " R1 resume"}, nextPc, land + 32'd4);
    stepEdge();
  endtask

  localparam logic [31:0] VALS [7] = '{32'hFFFF_FFFB, 32'hFFFF_FFFF, 32'h0,
                                       32'h1, 32'h7, 32'h8000_0000, 32'h7FFF_FFFF};

  initial begin
    #400000;
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] pc;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    // R13 reset state
    present(32'h0000_0000, 32'h0000_1000, 0, 0);
    chk("R13 reset nextPc", nextPc, 32'h0000_1004);
    chk("R13 reset idle", {31'd0, idleFlag}, 32'd0);
    chk("R13 reset linkWe", {31'd0, linkWe}, 32'd0);
    stepEdge();

    // R7 / R4 sweep over opcodes 4..7 and operand pairs
    pc = 32'h0000_2000;
    for (int op = 4; op <= 7; op++) begin
      for (int a = 0; a < 7; a++) begin
        for (int b = 0; b < 7; b++) begin
          logic signed [31:0] sa, sb;
          bit tk;
          logic [15:0] imm;
          sa = VALS[a]; sb = VALS[b];
          imm = (b[0]) ? 16'hFFF0 : 16'h0010;
          case (op)
            4: tk = (sa == sb);
            5: tk = (sa != sb);
            6: tk = (sa <= 0);
            default: tk = (sa > 0);
          endcase
          runSeq("R7/R4 cond", enc(op, 4, imm), pc, VALS[a], VALS[b], tk, relOf(pc, imm), 1'b0, 5'd0);
          pc = pc + 32'h100;
        end
      end
    end

    // R8 opcode-1 codes, with R9 link-on-taken
    for (int c = 0; c < 4; c++) begin
      for (int a = 0; a < 7; a++) begin
        int code;
        logic signed [31:0] sa;
        bit tk;
        code = (c[1] ? 16 : 0) + (c[0] ? 1 : 0);
        sa = VALS[a];
        tk = c[0] ? (sa >= 0) : (sa < 0);
        runSeq("R8 regimm", enc(1, code, 16'h0020), pc, VALS[a], 32'd0, tk,
               relOf(pc, 16'h0020), c[1] && tk, 5'd31);
        pc = pc + 32'h100;
      end
    end
    // R8 illegal codes have no effect
    runSeq("R8 illegal code 2", enc(1, 2, 16'h0020), pc, 32'hFFFF_FFFF, 0, 1'b0, 0, 1'b0, 0);
    runSeq("R8 illegal code 0x12", enc(1, 5'h12, 16'h0020), pc, 32'd5, 0, 1'b0, 0, 1'b0, 0);

    // R5 absolute jumps, R9 jal link to 31
    runSeq("R5 jump abs", {6'd2, 26'h123_4567}, 32'hA000_0040, 0, 0, 1'b1,
           32'hA48D_159C, 1'b0, 0);
    runSeq("R5/R9 jal abs", {6'd3, 26'h000_0100}, 32'h7FFF_FFF8, 0, 0, 1'b1,
           32'h7000_0400, 1'b1, 5'd31);

    // R6 register jumps, misaligned target bits cleared; R9 jalr rd
    runSeq("R6 jr", {6'd0, 5'd4, 15'd0, 6'd8}, 32'h0000_4000, 32'h0000_8003, 0, 1'b1,
           32'h0000_8003, 1'b0, 0);
    runSeq("R6/R9 jalr rd=9", {6'd0, 5'd4, 5'd0, 5'd9, 5'd0, 6'd9}, 32'h0000_5000,
           32'h0001_0000, 0, 1'b1, 32'h0001_0000, 1'b1, 5'd9);

    // R3 jump in delay slot is ignored
    present({6'd2, 26'h000_1000}, 32'h0000_6000, 0, 0);
    chk("R3 first jump pc+4", nextPc, 32'h0000_6004);
    stepEdge();
    present({6'd3, 26'h000_2000}, 32'h0000_6004, 0, 0);
    chk("R3 slot jal no link", {31'd0, linkWe}, 32'd0);
    chk("R3 slot goes to first target", nextPc, 32'h0000_4000);
    stepEdge();
    present(32'h0, 32'h0000_4000, 0, 0);
    chk("R3 no second redirect", nextPc, 32'h0000_4004);
    stepEdge();

    // R10 idle loop: beq to itself with nop in slot
    present(enc(4, 3, 16'hFFFF), 32'h0000_7000, 32'd1, 32'd1);
    stepEdge();
    present(32'h0, 32'h0000_7004, 0, 0);
    chk("R10 idle raised", {31'd0, idleFlag}, 32'd1);
    chk("R10 idle target", nextPc, 32'h0000_7000);
    stepEdge();
    present(enc(4, 3, 16'hFFFF), 32'h0000_7000, 32'd1, 32'd1);
    stepEdge();
    present(32'h2408_0001, 32'h0000_7004, 0, 0);
    chk("R10 non-nop slot not idle", {31'd0, idleFlag}, 32'd0);
    stepEdge();
    present(32'h0, 32'h0000_7000, 0, 0);
    chk("R10 no idle outside slot", {31'd0, idleFlag}, 32'd0);
    stepEdge();

    // R11 stall inside sequence
    present({6'd2, 26'h000_3000}, 32'h0000_9000, 0, 0);
    stall = 1'b1; #0;
    present({6'd2, 26'h000_3000}, 32'h0000_9000, 0, 0);
    chk("R11 stalled branch holds pc", nextPc, 32'h0000_9000);
    stepEdge();
    stall = 1'b0;
    present({6'd2, 26'h000_3000}, 32'h0000_9000, 0, 0);
    chk("R11 stalled branch left no state", nextPc, 32'h0000_9004);
    stepEdge();
    stall = 1'b1;
    present(32'h0, 32'h0000_9004, 0, 0);
    chk("R11 stalled slot holds pc", nextPc, 32'h0000_9004);
    stepEdge();
    stall = 1'b0;
    present(32'h0, 32'h0000_9004, 0, 0);
    chk("R11 slot after stall redirects", nextPc, 32'h0000_C000);
    stepEdge();

    // R12 flush cancels pending redirect
    present({6'd2, 26'h000_3000}, 32'h0000_A000, 0, 0);
    stepEdge();
    flush = 1'b1;
    present(32'h0, 32'h0000_A004, 0, 0);
    chk("R12 flush slot pc+4", nextPc, 32'h0000_A008);
    stepEdge();
    flush = 1'b0;
    present(32'h0, 32'h0000_A008, 0, 0);
    chk("R12 after flush sequential", nextPc, 32'h0000_A00C);
    stepEdge();

    // R1 plain sequential
    present(32'h2408_0001, 32'hFFFF_FFFC, 0, 0);
    chk("R1 sequential wrap", nextPc, 32'h0000_0000);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule